// File: doc/BRIEF.md
# Output Port Register with Per-Pin Source Selection

This block holds the general-purpose output port register of a two-channel serial controller and drives its eight output pins. Software never writes the register as a whole. One command address sets the register bits that carry a 1 on the data bus, and a second command address clears them. Bits that carry a 0 stay as they were. Software can therefore change single bits without keeping a shadow copy of the register.

Each pin is active-low with respect to the register: a stored 1 pulls its pin low. The pins above the two lowest can show an internal status line in place of the register bit. The choice is made per pair of pins by a 2-bit field of a configuration word, and the status lines are transmitter/receiver ready flags, interrupt flags and clock taps. The two lowest pins belong to the two channels' receivers. When a channel's flow-control mode is on, its pin becomes the NAND of the stored bit and that receiver's request-to-send line. The stored value is readable through a readback port.

Top module: `opmux_top`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), the register is all zeros and every pin is high.
- R2: A write strobe with address 0xE sets each register bit whose data bit is 1. Every other bit keeps its value. The readback shows the change after the clock edge that samples the strobe.
- R3: A write strobe with address 0xF clears each register bit whose data bit is 1. Every other bit keeps its value.
- R4: A write to any other address, or any cycle without the write strobe, leaves the register unchanged.
- R5: A pin sourced from the register drives the complement of its bit. The pin changes after the same clock edge that updates the register, and not before it.
- R6: The pin pairs {2,3}, {4,5} and {6,7} take their source from configuration bits [1:0], [3:2] and [5:4]. The codes are: 00 selects the register, 01 selects the ready flag, 10 selects the interrupt flag, and 11 selects the clock tap. A selected status line passes uninverted. Status vector bit k belongs to pin k+2.
- R7: With a channel's flow-control enable low (bit 0 for pin 0, bit 1 for pin 1), that pin follows the complement of its register bit. The configuration word has no effect on these two pins.
- R8: With a channel's flow-control enable high, its pin is the NAND of the register bit and that channel's request-to-send input. A register bit of 0 holds the pin high.
- R9: Turning flow control on or off leaves the stored register value unchanged, and the pin then returns to following the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data (bit mask for set/clear) |
| cfg_src | input | 6 | Source select, two bits per pin pair for pins 2..7 |
| flow_en | input | 2 | Per-channel receiver flow-control enable for pins 0 and 1 |
| rts | input | 2 | Per-channel receiver request-to-send, active high |
| sig_ready | input | 6 | Ready flags for pins 2..7 |
| sig_irq | input | 6 | Interrupt flags for pins 2..7 |
| sig_clock | input | 6 | Clock taps for pins 2..7 |
| port_pin | output | 8 | Output port pins |
| port_reg | output | 8 | Register readback |

## Verification
Register commands land one edge after the strobe is sampled. The readback and every register-sourced pin are therefore due at the falling edge that follows that rising edge, and the bench samples them there. One directed check looks at the pins between the strobe and the edge, to confirm that nothing moves early. The source selects, flow-control enables and status inputs reach the pins through logic only, with no register in the path. The bench changes them together with a bus cycle and checks them at the same falling edge, where both effects have settled.

// File: rtl/opmux_pkg.sv
package opmux_pkg;
   typedef enum logic [1:0] {
      SRC_REG   = 2'b00,
      SRC_READY = 2'b01,
      SRC_IRQ   = 2'b10,
      SRC_CLOCK = 2'b11
   } src_e;
endpackage

// File: rtl/opmux_reg.sv
module opmux_reg #(
   parameter int W        = 8,
   parameter int AW       = 4,
   parameter logic [AW-1:0] SET_ADDR = 4'hE,
   parameter logic [AW-1:0] CLR_ADDR = 4'hF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          wr,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  q
);
   if (SET_ADDR == CLR_ADDR) begin : g_bad_addr
      $error("opmux_reg: set and clear addresses must differ");
   end

   logic hit_set, hit_clr;
   assign hit_set = wr && (addr == SET_ADDR);
   assign hit_clr = wr && (addr == CLR_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (hit_set) q <= q | wdata;
      else if (hit_clr) q <= q & ~wdata;
   end

   AST_SET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == SET_ADDR) |=> (q == ($past(q) | $past(wdata)))); // R2
   AST_CLR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == CLR_ADDR) |=> (q == ($past(q) & ~$past(wdata)))); // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr || (addr != SET_ADDR && addr != CLR_ADDR)) |=> $stable(q)); // R4
endmodule

// File: rtl/opmux_sel.sv
module opmux_sel
   import opmux_pkg::*;
#(
   parameter int NALT = 6,
   localparam int NG  = NALT / 2
) (
   input  logic [NALT-1:0] reg_bits,
   input  logic [2*NG-1:0] cfg,
   input  logic [NALT-1:0] ready,
   input  logic [NALT-1:0] irq,
   input  logic [NALT-1:0] clk_tap,
   output logic [NALT-1:0] pins
);
   for (genvar k = 0; k < NALT; k++) begin : g_pin
      src_e src;
      assign src = src_e'(cfg[2*(k/2) +: 2]);
      always_comb begin
         unique case (src)
            SRC_READY: pins[k] = ready[k];
            SRC_IRQ:   pins[k] = irq[k];
            SRC_CLOCK: pins[k] = clk_tap[k];
            default:   pins[k] = ~reg_bits[k];
         endcase
      end
   end
endmodule

// File: rtl/opmux_flow.sv
module opmux_flow #(
   parameter int NCH = 2
) (
   input  logic [NCH-1:0] reg_bits,
   input  logic [NCH-1:0] en,
   input  logic [NCH-1:0] rts,
   output logic [NCH-1:0] pins
);
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign pins[c] = en[c] ? ~(reg_bits[c] & rts[c]) : ~reg_bits[c];
   end
endmodule

// File: rtl/opmux_top.sv
module opmux_top
   import opmux_pkg::*;
#(
   parameter int NPINS = 8,
   parameter int AW    = 4,
   parameter logic [AW-1:0] SET_ADDR = 4'hE,
   parameter logic [AW-1:0] CLR_ADDR = 4'hF,
   localparam int NCH  = 2,
   localparam int NALT = NPINS - NCH,
   localparam int NG   = NALT / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    bus_addr,
   input  logic             bus_wr,
   input  logic [NPINS-1:0] bus_wdata,
   input  logic [2*NG-1:0]  cfg_src,
   input  logic [NCH-1:0]   flow_en,
   input  logic [NCH-1:0]   rts,
   input  logic [NALT-1:0]  sig_ready,
   input  logic [NALT-1:0]  sig_irq,
   input  logic [NALT-1:0]  sig_clock,
   output logic [NPINS-1:0] port_pin,
   output logic [NPINS-1:0] port_reg
);
   if (NPINS < NCH + 2 || (NALT % 2) != 0) begin : g_bad_width
      $error("opmux_top: NPINS must leave an even, nonzero number of pins above the flow pins");
   end

   logic [NALT-1:0] alt_pins;
   logic [NCH-1:0]  flow_pins;

   opmux_reg #(.W(NPINS), .AW(AW), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)) u_reg (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
      .wdata(bus_wdata), .q(port_reg)
   );

   opmux_flow #(.NCH(NCH)) u_flow (
      .reg_bits(port_reg[NCH-1:0]), .en(flow_en), .rts(rts), .pins(flow_pins)
   );

   opmux_sel #(.NALT(NALT)) u_sel (
      .reg_bits(port_reg[NPINS-1:NCH]), .cfg(cfg_src), .ready(sig_ready),
      .irq(sig_irq), .clk_tap(sig_clock), .pins(alt_pins)
   );

   assign port_pin = {alt_pins, flow_pins};

   AST_REG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_src[1:0] == SRC_REG) |-> (port_pin[NCH] == !port_reg[NCH])); // R5
   AST_READY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_src[1:0] == SRC_READY) |-> (port_pin[NCH] == sig_ready[0])); // R6
   AST_FLOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !flow_en[0] |-> (port_pin[0] == !port_reg[0])); // R7
   AST_FLOW_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_en[0] && !port_reg[0]) |-> port_pin[0]); // R8
endmodule

// File: tb/opmux_top_test.sv
module opmux_top_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [5:0] cfg_src = '0;
   logic [1:0] flow_en = '0;
   logic [1:0] rts = '0;
   logic [5:0] sig_ready = '0, sig_irq = '0, sig_clock = '0;
   logic [7:0] port_pin, port_reg;

   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   opmux_top uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .cfg_src(cfg_src), .flow_en(flow_en), .rts(rts),
      .sig_ready(sig_ready), .sig_irq(sig_irq), .sig_clock(sig_clock),
      .port_pin(port_pin), .port_reg(port_reg)
   );

   typedef struct packed {
      logic [3:0] req;
      logic [3:0] addr;
      logic       wr;
      logic [7:0] data;
      logic [5:0] cfg;
      logic [1:0] flow;
      logic [1:0] rts;
      logic [5:0] rdy;
      logic [5:0] irq;
      logic [5:0] clk;
      logic [7:0] ereg;
      logic [7:0] epin;
   } vec_t;

   // Requirement tags in the table: R2 R3 R4 R5 R6 R8 R9
   localparam int NVEC = 16;
   localparam vec_t VEC [NVEC] = '{
      '{4'd2, 4'hE, 1'b1, 8'hA5, 6'b000000, 2'b00, 2'b00, 6'b0, 6'b0, 6'b0, 8'hA5, 8'h5A},
      '{4'd3, 4'hF, 1'b1, 8'h81, 6'b000000, 2'b00, 2'b00, 6'b0, 6'b0, 6'b0, 8'h24, 8'hDB},
      '{4'd2, 4'hE, 1'b1, 8'h00, 6'b000000, 2'b00, 2'b00, 6'b0, 6'b0, 6'b0, 8'h24, 8'hDB},
      '{4'd4, 4'hE, 1'b0, 8'hFF, 6'b000000, 2'b00, 2'b00, 6'b0, 6'b0, 6'b0, 8'h24, 8'hDB},
      '{4'd4, 4'h3, 1'b1, 8'hFF, 6'b000000, 2'b00, 2'b00, 6'b0, 6'b0, 6'b0, 8'h24, 8'hDB},
      '{4'd3, 4'hF, 1'b1, 8'h0F, 6'b000000, 2'b00, 2'b00, 6'b0, 6'b0, 6'b0, 8'h20, 8'hDF},
      '{4'd6, 4'hE, 1'b1, 8'h0F, 6'b000001, 2'b00, 2'b00, 6'b000001, 6'b0, 6'b0, 8'h2F, 8'hD4},
      '{4'd6, 4'h0, 1'b0, 8'h00, 6'b111000, 2'b00, 2'b00, 6'b0, 6'b001100, 6'b010000, 8'h2F, 8'h70},
      '{4'd8, 4'h0, 1'b0, 8'h00, 6'b000000, 2'b01, 2'b01, 6'b0, 6'b0, 6'b0, 8'h2F, 8'hD0},
      '{4'd8, 4'h0, 1'b0, 8'h00, 6'b000000, 2'b01, 2'b00, 6'b0, 6'b0, 6'b0, 8'h2F, 8'hD1},
      '{4'd8, 4'hF, 1'b1, 8'h03, 6'b000000, 2'b11, 2'b10, 6'b0, 6'b0, 6'b0, 8'h2C, 8'hD3},
      '{4'd9, 4'h0, 1'b0, 8'h00, 6'b000000, 2'b00, 2'b00, 6'b0, 6'b0, 6'b0, 8'h2C, 8'hD3},
      '{4'd8, 4'hE, 1'b1, 8'h03, 6'b000000, 2'b11, 2'b11, 6'b0, 6'b0, 6'b0, 8'h2F, 8'hD0},
      '{4'd9, 4'h0, 1'b0, 8'h00, 6'b000000, 2'b00, 2'b11, 6'b0, 6'b0, 6'b0, 8'h2F, 8'hD0},
      '{4'd5, 4'hE, 1'b1, 8'hFF, 6'b000000, 2'b00, 2'b00, 6'b0, 6'b0, 6'b0, 8'hFF, 8'h00},
      '{4'd5, 4'hF, 1'b1, 8'hFF, 6'b000000, 2'b00, 2'b00, 6'b0, 6'b0, 6'b0, 8'h00, 8'hFF}
   };

   task automatic check8(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
      end
   endtask

   task automatic idle_bus();
      bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: reset state
      #(CLK_PERIOD * 2 + 2);
      check8("R1", "reg in reset", port_reg, 8'h00);
      check8("R1", "pins in reset", port_pin, 8'hFF);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         bus_addr = VEC[i].addr; bus_wr = VEC[i].wr; bus_wdata = VEC[i].data;
         cfg_src = VEC[i].cfg; flow_en = VEC[i].flow; rts = VEC[i].rts;
         sig_ready = VEC[i].rdy; sig_irq = VEC[i].irq; sig_clock = VEC[i].clk;
         @(posedge clk);
         @(negedge clk);
         check8($sformatf("R%0d", VEC[i].req), $sformatf("reg vec %0d", i), port_reg, VEC[i].ereg);
         check8($sformatf("R%0d", VEC[i].req), $sformatf("pin vec %0d", i), port_pin, VEC[i].epin);
      end

      // R5: a set command does not reach the pins before the clock edge
      cfg_src = '0; flow_en = '0; rts = '0;
      sig_ready = '0; sig_irq = '0; sig_clock = '0;
      bus_addr = 4'hE; bus_wr = 1'b1; bus_wdata = 8'h3C;
      #1;
      check8("R5", "pins before edge", port_pin, 8'hFF);
      @(posedge clk);
      @(negedge clk);
      idle_bus();
      check8("R5", "pins after edge", port_pin, 8'hC3);

      // R1: asynchronous reset mid-run
      #1 rst_n = 1'b0;
      #1;
      check8("R1", "reg after mid reset", port_reg, 8'h00);
      check8("R1", "pins after mid reset", port_pin, 8'hFF);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: configuration word has no effect on pins 0 and 1
      bus_addr = 4'hE; bus_wr = 1'b1; bus_wdata = 8'h01;
      cfg_src = 6'b111111; sig_ready = '1; sig_irq = '1; sig_clock = '1;
      @(posedge clk);
      @(negedge clk);
      idle_bus();
      check8("R7", "flow pins with cfg all-ones", port_pin & 8'h03, 8'h02);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule